// File: doc/BRIEF.md
# Frame-Decimated Pixel Dump Register

This block lets a slow host pull a complete sensor image out through a single byte-wide register, one pixel per frame. A pixel stream arrives every frame: a frame-start flag, a valid strobe and a 6-bit value per pixel. The block keeps a pointer to the pixel the host wants next. After any host access it waits for the start of a new frame, picks out the pixel whose position in that frame equals the pointer, and holds it until the host reads it, however long that takes.

A read returns one byte. Bit 7 marks the first pixel of the image, bit 6 says the pixel is valid, and bits 5 to 0 carry the pixel. A read that finds a held pixel advances the pointer, wrapping after the last pixel of the frame. A read that comes too early returns an all-zero byte and leaves the pointer where it is. A write moves the pointer back to the first pixel. Every access, read or write, discards what was held and arms a new capture, so the host assembles an image of NPIX pixels in at least NPIX frames.

Top module: `pixdump_port`

## Requirements
- R1: The read byte appears on `rd_data` in the clock cycle after `rd_stb` and stays until the next read. Bit 7 is start-of-image, bit 6 is data-valid and bits 5:0 are the pixel. A byte with data-valid 0 is 0x00.
- R2: A cycle with both `frm_start` and `pix_vld` high carries pixel position 0. Each later `pix_vld` cycle carries the next position. `frm_start` without `pix_vld` has no effect, and positions at or beyond NPIX never match the pointer.
- R3: Any access arms a capture that takes only pixels from frames that begin after the access. The captured pixel is held unchanged across any number of later frames until the next access.
- R4: A read made while no captured pixel is held returns 0x00 and leaves the pointer unchanged.
- R5: A read that returns data-valid 1 advances the pointer by one. After NPIX such reads the pointer is back at pixel 0.
- R6: Start-of-image (bit 7) is 1 exactly when data-valid is 1 and the pixel returned is position 0.
- R7: A write sets the pointer to pixel 0, discards any held pixel and leaves `rd_data` unchanged.
- R8: A cycle with `rd_stb` and `wr_stb` both high acts as a write only.
- R9: After reset the pointer is 0, `rd_data` is 0x00 and no capture is armed, so frames before the first access capture nothing.
- R10: If an armed frame ends before reaching the pointer's position, the capture keeps looking in the following frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frm_start | input | 1 | Marks the first pixel of a frame (qualified by `pix_vld`) |
| pix_vld | input | 1 | Pixel present on `pix_val` this cycle |
| pix_val | input | PIXW | Pixel value |
| rd_stb | input | 1 | Register read request, one cycle |
| wr_stb | input | 1 | Register write request, one cycle |
| rd_data | output | PIXW+2 | Flags and pixel returned by the last read |

## Verification
The bench builds the block with NPIX set to 10 instead of the full image size. This lets the pointer wrap many times within the run and lets the random frames be both shorter and longer than the image. As a result, frames that run out before the pointer and pixels beyond the last position both occur often. The pixel width stays at 6, so the full range of flag and value bits is exercised.

// File: rtl/pixdump_pkg.sv
// Shared types for the pixel dump register.
// Assumes: flags sit directly above a PIXW-bit pixel in the read byte.
package pixdump_pkg;

    typedef enum logic [1:0] {
        CAP_IDLE  = 2'd0,   // nothing armed since reset
        CAP_ARMED = 2'd1,   // waiting for a fresh frame start
        CAP_HUNT  = 2'd2,   // inside a frame, looking for the pointer position
        CAP_FULL  = 2'd3    // pixel held for the host
    } cap_state_t;

endpackage

// File: rtl/pixdump_pos.sv
// Tracks the position of the current pixel within its frame.
// Assumes: a frame start is only meaningful together with pix_vld;
// the counter saturates at NPIX so oversize frames never alias.
module pixdump_pos #(
    parameter int NPIX = 324,
    localparam int CW  = $clog2(NPIX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frm_start,
    input  logic          pix_vld,
    output logic [CW-1:0] cur_pos,
    output logic          sof_ev
);
    logic [CW-1:0] cnt_q;

    assign sof_ev  = frm_start && pix_vld;
    assign cur_pos = sof_ev ? '0 : cnt_q;

    // Count pixels since the last frame start, saturating at NPIX.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= CW'(NPIX);
        else if (pix_vld)
            cnt_q <= (cur_pos == CW'(NPIX)) ? CW'(NPIX) : cur_pos + 1'b1;
    end
endmodule

// File: rtl/pixdump_ptr.sv
// Holds the index of the pixel the host wants next, wrapping at NPIX.
// Assumes: clr has priority over adv.
module pixdump_ptr #(
    parameter int NPIX = 324,
    localparam int IW  = $clog2(NPIX)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          adv,
    output logic [IW-1:0] ptr
);
    // Clear on write, step on a valid read, wrap after the last pixel.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            ptr <= '0;
        else if (adv)
            ptr <= (ptr == IW'(NPIX - 1)) ? '0 : ptr + 1'b1;
    end
endmodule

// File: rtl/pixdump_cap.sv
// Capture controller: arms on any access, grabs one pixel per frame
// at the pointer position, and builds the read byte.
// Assumes: acc_wr already includes simultaneous read+write cycles.
module pixdump_cap
    import pixdump_pkg::*;
#(
    parameter int PIXW = 6,
    localparam int BW  = PIXW + 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            acc_rd,
    input  logic            acc_wr,
    input  logic            sof_ev,
    input  logic            pix_vld,
    input  logic            hit,
    input  logic            ptr_zero,
    input  logic [PIXW-1:0] pix_val,
    output logic            full,
    output logic            adv,
    output logic [PIXW-1:0] hold,
    output logic [BW-1:0]   rd_data
);
    cap_state_t st_q;

    assign full = (st_q == CAP_FULL);
    assign adv  = acc_rd && full;

    // Sequence the arm / hunt / hold states.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= CAP_IDLE;
        end else if (acc_rd || acc_wr) begin
            st_q <= CAP_ARMED;
        end else begin
            unique case (st_q)
                CAP_ARMED: if (sof_ev) st_q <= hit ? CAP_FULL : CAP_HUNT;
                CAP_HUNT:  if (pix_vld && hit) st_q <= CAP_FULL;
                default:   st_q <= st_q;
            endcase
        end
    end

    // Latch the pixel on the cycle the capture completes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold <= '0;
        else if (!(acc_rd || acc_wr) && pix_vld && hit &&
                 ((st_q == CAP_HUNT) || (st_q == CAP_ARMED && sof_ev)))
            hold <= pix_val;
    end

    // Register the byte returned to the host on each read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (acc_rd)
            rd_data <= full ? {ptr_zero, 1'b1, hold} : '0;
    end
endmodule

// File: rtl/pixdump_port.sv
// Top of the pixel dump register: frame position tracking, pointer
// and capture controller. One pixel per frame reaches the host.
// Assumes: rd_stb and wr_stb are single-cycle strobes in the clk domain.
module pixdump_port #(
    parameter int NPIX = 324,
    parameter int PIXW = 6,
    localparam int CW  = $clog2(NPIX + 1),
    localparam int IW  = $clog2(NPIX),
    localparam int BW  = PIXW + 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frm_start,
    input  logic            pix_vld,
    input  logic [PIXW-1:0] pix_val,
    input  logic            rd_stb,
    input  logic            wr_stb,
    output logic [BW-1:0]   rd_data
);
    logic [CW-1:0]   cur_pos;
    logic            sof_ev;
    logic [IW-1:0]   ptr_q;
    logic            full_q;
    logic            adv;
    logic [PIXW-1:0] hold_q;
    logic            acc_rd;
    logic            hit;

    assign acc_rd = rd_stb && !wr_stb;
    assign hit    = (cur_pos == CW'(ptr_q));

    pixdump_pos #(.NPIX(NPIX)) u_pos (
        .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .pix_vld(pix_vld),
        .cur_pos(cur_pos), .sof_ev(sof_ev)
    );

    pixdump_ptr #(.NPIX(NPIX)) u_ptr (
        .clk(clk), .rst_n(rst_n), .clr(wr_stb), .adv(adv), .ptr(ptr_q)
    );

    pixdump_cap #(.PIXW(PIXW)) u_cap (
        .clk(clk), .rst_n(rst_n), .acc_rd(acc_rd), .acc_wr(wr_stb),
        .sof_ev(sof_ev), .pix_vld(pix_vld), .hit(hit),
        .ptr_zero(ptr_q == '0), .pix_val(pix_val),
        .full(full_q), .adv(adv), .hold(hold_q), .rd_data(rd_data)
    );
endmodule

// File: rtl/pixdump_chk.sv
// Protocol checker for pixdump_port, attached by bind.
// Assumes: ptr, full and hold are the top's internal pointer, held flag
// and held pixel.
module pixdump_chk #(
    parameter int NPIX = 324,
    parameter int PIXW = 6,
    localparam int IW  = $clog2(NPIX),
    localparam int BW  = PIXW + 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            rd_stb,
    input logic            wr_stb,
    input logic [BW-1:0]   rd_data,
    input logic [IW-1:0]   ptr,
    input logic            full,
    input logic [PIXW-1:0] hold
);
    // R6: start-of-image never without data-valid
    a_r6_sof_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[BW-1] |-> rd_data[BW-2]);

    // R4: early read returns zero and keeps the pointer
    a_r4_early_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !wr_stb && !full) |=> (rd_data == '0) && $stable(ptr));

    // R5: valid read steps the pointer with wrap
    a_r5_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !wr_stb && full) |=> rd_data[BW-2] &&
        (ptr == (($past(ptr) == IW'(NPIX - 1)) ? '0 : $past(ptr) + 1'b1)));

    // R7: write clears pointer and leaves the read byte alone
    a_r7_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> (ptr == '0) && $stable(rd_data) && !full);

    // R3: held pixel is stable until the next access
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !rd_stb && !wr_stb) |=> full && $stable(hold));

    // R1: read byte changes only on a read
    a_r1_byte_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_stb || wr_stb) |=> $stable(rd_data));
endmodule

bind pixdump_port pixdump_chk #(.NPIX(NPIX), .PIXW(PIXW)) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .rd_data(rd_data), .ptr(ptr_q), .full(full_q), .hold(hold_q)
);

// File: tb/tb_pixdump_port.sv
module tb_pixdump_port;
    localparam int NPIX = 10;
    localparam int PIXW = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frm_start = 1'b0;
    logic       pix_vld = 1'b0;
    logic [5:0] pix_val = '0;
    logic       rd_stb = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] rd_data;

    int n_chk = 0;
    int n_err = 0;

    // model state
    int   m_ptr = 0;
    bit   m_pend = 0, m_hunt = 0, m_full = 0;
    logic [5:0] m_val = '0;
    logic [7:0] m_last = '0;
    int   fno = 0;

    always #10 clk = ~clk;

    pixdump_port #(.NPIX(NPIX), .PIXW(PIXW)) dut (
        .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .pix_vld(pix_vld),
        .pix_val(pix_val), .rd_stb(rd_stb), .wr_stb(wr_stb), .rd_data(rd_data)
    );

    function automatic logic [5:0] pix_of(int fr, int pos);
        return 6'((fr * 5 + pos * 11 + 3) & 63);
    endfunction

    task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: rd_data=%02h expected %02h", tag, got, exp);
        end
    endtask

    // One access cycle; model applies write priority (R8) and read rules.
    task automatic access(bit rd, bit wr, string tag);
        logic [7:0] exp;
        @(negedge clk);
        frm_start = 1'b0; pix_vld = 1'b0;
        rd_stb = rd; wr_stb = wr;
        @(negedge clk);
        rd_stb = 1'b0; wr_stb = 1'b0;
        if (wr) begin
            m_ptr = 0;
            exp = m_last;                      // R7, R8: byte unchanged
        end else if (m_full) begin
            exp = {m_ptr == 0, 1'b1, m_val};   // R1, R5, R6
            m_ptr = (m_ptr + 1) % NPIX;
        end else begin
            exp = 8'h00;                       // R4
        end
        if (rd || wr) chk(tag, rd_data, exp);
        m_last = exp;
        m_pend = 1; m_hunt = 0; m_full = 0;
    endtask

    // One frame of len pixels; optional access before pixel acc_at (R2, R3, R10).
    task automatic frame(int len, int acc_at, bit acc_wr, bit gaps);
        for (int pos = 0; pos < len; pos++) begin
            if (pos == acc_at) access(!acc_wr, acc_wr, "R3 mid-frame access");
            if (gaps && ($urandom % 4 == 0)) begin
                @(negedge clk);
                pix_vld = 1'b0; frm_start = ($urandom % 2 == 0); // R2 noise
            end
            @(negedge clk);
            frm_start = (pos == 0); pix_vld = 1'b1; pix_val = pix_of(fno, pos);
            if (pos == 0 && m_pend) begin m_hunt = 1; m_pend = 0; end
            if (m_hunt && pos == m_ptr) begin
                m_full = 1; m_hunt = 0; m_val = pix_of(fno, pos);
            end
        end
        @(negedge clk);
        frm_start = 1'b0; pix_vld = 1'b0;
        fno++;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_err++; n_chk++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 reset byte", rd_data, 8'h00);

        // R9: frames before any access capture nothing
        frame(NPIX, -1, 0, 0);
        access(1, 0, "R9 no capture without arming");
        // R6: first valid read is pixel 0 with start-of-image
        frame(NPIX, -1, 0, 0);
        access(1, 0, "R6 first pixel sof");
        // R4: read without an intervening frame
        access(1, 0, "R4 early read");
        // R3: held across several frames
        frame(NPIX, -1, 0, 0);
        frame(NPIX, -1, 0, 0);
        frame(NPIX, -1, 0, 0);
        access(1, 0, "R3 hold across frames");
        // R3: mid-frame access waits for next frame
        frame(NPIX, 5, 0, 0);
        access(1, 0, "R3 armed frame not reused");
        // R10: short frame misses pointer, later frame supplies it
        frame(NPIX, -1, 0, 0);
        access(1, 0, "R10 arm");
        frame(1, -1, 0, 0);
        frame(NPIX, -1, 0, 0);
        access(1, 0, "R10 capture after short frame");
        // R5: full wrap
        for (int k = 0; k < NPIX + 2; k++) begin
            frame(NPIX, -1, 0, 0);
            access(1, 0, "R5 wrap sequence");
        end
        // R7: write resets pointer
        access(0, 1, "R7 write");
        frame(NPIX, -1, 0, 0);
        access(1, 0, "R7 pixel 0 after write");
        // R8: simultaneous read and write
        frame(NPIX, -1, 0, 0);
        access(1, 1, "R8 rd+wr acts as write");
        frame(NPIX, -1, 0, 0);
        access(1, 0, "R8 pointer cleared");

        // Constrained random mix
        for (int i = 0; i < 400; i++) begin
            int op = $urandom % 10;
            if (op < 4)       access(1, 0, "R5 random read");
            else if (op == 4) access(0, 1, "R7 random write");
            else if (op == 5) access(1, 1, "R8 random rd+wr");
            else if (op == 6) frame($urandom % (NPIX + 1) + 1, $urandom % NPIX, $urandom % 2, 1);
            else              frame($urandom % (NPIX + 4) + 1, -1, 0, 1);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule